// File: doc/BRIEF.md
# Differential Clock Output Enable and Power-Down Controller

This block decides, for each of six differential clock outputs, whether the output toggles or sits in the low/low state. Four things take part in that decision: a power-good level that also serves as the power-down control, a per-output active-low enable pin, a per-output enable bit held in a configuration byte, and a lock indication from the PLL. The PLL and the clock path are not part of the block. The output clock reaches the block as a level `out_clk` sampled in the `clk` domain, and the block drives registered true and complement copies of it for every output.

Power-good has two roles. Its first rising level after reset captures the mode and address straps and starts the device. After that, a low level puts the device into power-down and a high level brings it back, and the captured straps do not change. The captured mode can select PLL bypass. In bypass the lock indication is ignored and the PLL enable stays off. An enable change is applied only on a falling edge of the output clock, so every high phase of a true or complement output lasts a full half period.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: Before the first power-good high after reset, and during every later power-down, all `dif_p` and `dif_n` bits are 0, `running` is 0 and `pll_enable` is 0, whatever the pins and the configuration byte hold.
- R2: While running and the PLL is ready, output i toggles exactly when its configuration bit is 1 and `oe_pin_n[i]` is 0. A toggling output has `dif_p[i]` equal to the value `out_clk` had at the previous `clk` edge and `dif_n[i]` equal to its inverse. A disabled output has both bits at 0.
- R3: The configuration byte resets to 8'hFF and loads `cfg_wdata` on a cycle with `cfg_we` high. Bits 0, 2, 3, 4, 6 and 7 enable outputs 0, 1, 2, 3, 4 and 5. Bits 1 and 5 have no effect on any output.
- R4: On the first power-good high after reset, `strap_mode` is captured to `mode_q` and `strap_addr` is captured and decoded to `bus_addr` (00 gives 7'h6B, 01 gives 7'h6C, 10 or 11 gives 7'h6D). Leaving power-down does not capture them again.
- R5: `mode_q` 2'b01 is bypass, 2'b00 is low bandwidth and 2'b1x is high bandwidth. Outside bypass, all outputs stay low/low while `pll_lock` is 0, and `pll_enable` equals `running`. In bypass, `pll_lock` is ignored and `pll_enable` is 0.
- R6: An output enable changes only at a `clk` edge where `out_clk` has just fallen. Every high run of any `dif_p` or `dif_n` bit therefore lasts one full half period of `out_clk`.
- R7: A change on `oe_pin_n` or on `pwr_good` appears at the outputs within three `out_clk` periods. Both inputs pass through a two-stage synchronizer.
- R8: While `rst` is high, all outputs are 0, `mode_q` is 2'b00 and `bus_addr` is 7'h6B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good / power-down level, asynchronous |
| oe_pin_n | input | 6 | Active-low per-output enable pins, asynchronous |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte write data |
| strap_mode | input | 2 | PLL mode strap |
| strap_addr | input | 2 | Bus address strap |
| pll_lock | input | 1 | PLL lock indication |
| out_clk | input | 1 | Sampled level of the output clock |
| dif_p | output | 6 | True output of each differential pair |
| dif_n | output | 6 | Complement output of each differential pair |
| pll_enable | output | 1 | PLL power-on request |
| running | output | 1 | Device started and not in power-down |
| mode_q | output | 2 | Captured mode strap |
| bus_addr | output | 7 | Decoded bus address from the captured strap |

## Verification
Most internal faults show up at the outputs within about three output clock periods. A wrong synchronizer depth or enable term leaves an output toggling or silent against the expected mask. A wrong bit map makes the wrong output respond to a single-bit write. A wrong sequencer state either makes re-captured straps appear at `mode_q` and `bus_addr` after leaving power-down, or keeps outputs low when they should run. An enable that updates away from the clock's falling edge shows up as a pulse shorter than the half period, on the true or the complement line, at the first enable or disable.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    localparam int NUM_OUT  = 6;
    localparam int CFG_W    = 8;
    localparam int ADDR_W   = 7;
    localparam int MODE_W   = 2;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_RUN   = 2'd1,
        PS_SLEEP = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [1:0]        addr_sel;
    } strap_t;

    // byte position that enables a given output lane
    function automatic int unsigned lane_bit(input int unsigned lane);
        case (lane)
            0: lane_bit = 0;
            1: lane_bit = 2;
            2: lane_bit = 3;
            3: lane_bit = 4;
            4: lane_bit = 6;
            default: lane_bit = 7;
        endcase
    endfunction

    function automatic logic [NUM_OUT-1:0] lanes_from_byte(input logic [CFG_W-1:0] b);
        logic [NUM_OUT-1:0] m;
        for (int unsigned i = 0; i < NUM_OUT; i++) begin
            m[i] = b[lane_bit(i)];
        end
        return m;
    endfunction

    function automatic logic mode_is_bypass(input logic [MODE_W-1:0] m);
        return (m == 2'b01);
    endfunction

    function automatic logic [ADDR_W-1:0] addr_decode(input logic [1:0] s);
        case (s)
            2'b00:   addr_decode = 7'h6B;
            2'b01:   addr_decode = 7'h6C;
            default: addr_decode = 7'h6D;
        endcase
    endfunction

endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RESET_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cg_cfg_reg.sv
`timescale 1ns/1ps
module cg_cfg_reg
    import clkgate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [CFG_W-1:0]   wdata,
    output logic [NUM_OUT-1:0] lane_oe
);

    // only the six lane bits are stored; the two spare positions are dropped
    logic [NUM_OUT-1:0] oe_q;

    always_ff @(posedge clk) begin
        if (rst)     oe_q <= '1;
        else if (we) oe_q <= lanes_from_byte(wdata);
    end

    assign lane_oe = oe_q;

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !$past(we) |-> $stable(oe_q))
        else $error("a_r3_hold_without_write");

endmodule

// File: rtl/cg_pwr_seq.sv
`timescale 1ns/1ps
module cg_pwr_seq
    import clkgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pg_i,
    input  strap_t     strap_i,
    output pwr_state_e state_o,
    output strap_t     strap_o
);

    pwr_state_e state_q;
    strap_t     strap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            strap_q <= '0;
        end else begin
            case (state_q)
                PS_IDLE: if (pg_i) begin
                    state_q <= PS_RUN;
                    strap_q <= strap_i;
                end
                PS_RUN:   if (!pg_i) state_q <= PS_SLEEP;
                PS_SLEEP: if (pg_i)  state_q <= PS_RUN;
                default:  state_q <= PS_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign strap_o = strap_q;

    a_r4_straps_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_IDLE && $past(state_q) != PS_IDLE) |-> $stable(strap_q))
        else $error("a_r4_straps_frozen");

    a_r4_no_return_idle: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) != PS_IDLE) |-> (state_q != PS_IDLE))
        else $error("a_r4_no_return_idle");

    a_r1_run_needs_pg: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN && $past(state_q) != PS_RUN) |-> $past(pg_i))
        else $error("a_r1_run_needs_pg");

endmodule

// File: rtl/cg_lane.sv
`timescale 1ns/1ps
module cg_lane (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    input  logic oc_i,
    input  logic req_i,
    output logic dif_p_o,
    output logic dif_n_o
);

    logic en_q;
    logic en_nxt;

    // the enable moves only when the output clock has just dropped
    always_comb en_nxt = fall_i ? req_i : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            dif_p_o <= 1'b0;
            dif_n_o <= 1'b0;
        end else begin
            en_q    <= en_nxt;
            dif_p_o <= oc_i & en_nxt;
            dif_n_o <= ~oc_i & en_nxt;
        end
    end

    a_r6_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_q) |-> $past(fall_i))
        else $error("a_r6_change_on_fall");

    a_r2_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(req_i))
        else $error("a_r2_rise_needs_req");

    a_r6_comp_start: assert property (@(posedge clk) disable iff (rst)
        $rose(dif_n_o) |-> $past(fall_i))
        else $error("a_r6_comp_start");

    a_r6_true_start: assert property (@(posedge clk) disable iff (rst)
        $rose(dif_p_o) |-> ($past(oc_i) && $past(en_q)))
        else $error("a_r6_true_start");

endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwr_good,
    input  logic [5:0]   oe_pin_n,
    input  logic         cfg_we,
    input  logic [7:0]   cfg_wdata,
    input  logic [1:0]   strap_mode,
    input  logic [1:0]   strap_addr,
    input  logic         pll_lock,
    input  logic         out_clk,
    output logic [5:0]   dif_p,
    output logic [5:0]   dif_n,
    output logic         pll_enable,
    output logic         running,
    output logic [1:0]   mode_q,
    output logic [6:0]   bus_addr
);

    logic [NUM_OUT-1:0] pin_n_s;
    logic               pg_s;
    logic [NUM_OUT-1:0] lane_oe;
    logic [NUM_OUT-1:0] lane_req;
    pwr_state_e         pstate;
    strap_t             strap_in;
    strap_t             strap_q;
    logic               oc_d;
    logic               oc_fall;
    logic               bypass;
    logic               pll_ready;

    cg_sync #(.WIDTH(NUM_OUT), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_pin_sync (
        .clk(clk), .rst(rst), .d(oe_pin_n), .q(pin_n_s)
    );

    cg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pg_sync (
        .clk(clk), .rst(rst), .d(pwr_good), .q(pg_s)
    );

    cg_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .lane_oe(lane_oe)
    );

    assign strap_in = '{mode: strap_mode, addr_sel: strap_addr};

    cg_pwr_seq u_seq (
        .clk(clk), .rst(rst), .pg_i(pg_s), .strap_i(strap_in),
        .state_o(pstate), .strap_o(strap_q)
    );

    always_ff @(posedge clk) begin
        if (rst) oc_d <= 1'b0;
        else     oc_d <= out_clk;
    end

    assign oc_fall   = oc_d & ~out_clk;
    assign running   = (pstate == PS_RUN);
    assign bypass    = mode_is_bypass(strap_q.mode);
    assign pll_ready = bypass | pll_lock;
    assign pll_enable = running & ~bypass;
    assign mode_q    = strap_q.mode;
    assign bus_addr  = addr_decode(strap_q.addr_sel);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        assign lane_req[g] = running & pll_ready & lane_oe[g] & ~pin_n_s[g];

        cg_lane u_lane (
            .clk(clk), .rst(rst), .fall_i(oc_fall), .oc_i(out_clk),
            .req_i(lane_req[g]), .dif_p_o(dif_p[g]), .dif_n_o(dif_n[g])
        );
    end

    a_r5_bypass_pll_off: assert property (@(posedge clk) disable iff (rst)
        bypass |-> !pll_enable)
        else $error("a_r5_bypass_pll_off");

    a_r1_pll_needs_run: assert property (@(posedge clk) disable iff (rst)
        pll_enable |-> running)
        else $error("a_r1_pll_needs_run");

    a_r2_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
        (dif_p & dif_n) == '0)
        else $error("a_r2_pair_exclusive");

endmodule

// File: tb/clkout_gate_ctrl_tb.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_tb;

    localparam int HALF = 4;
    localparam int SETTLE = 3 * 2 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_good = 1'b0;
    logic [5:0] oe_pin_n = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] strap_mode = '0;
    logic [1:0] strap_addr = '0;
    logic       pll_lock = 1'b0;
    logic       out_clk = 1'b0;
    logic [5:0] dif_p, dif_n;
    logic       pll_enable, running;
    logic [1:0] mode_q;
    logic [6:0] bus_addr;

    always #2.5 clk = ~clk;

    clkout_gate_ctrl u_dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .oe_pin_n(oe_pin_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .strap_mode(strap_mode),
        .strap_addr(strap_addr), .pll_lock(pll_lock), .out_clk(out_clk),
        .dif_p(dif_p), .dif_n(dif_n), .pll_enable(pll_enable),
        .running(running), .mode_q(mode_q), .bus_addr(bus_addr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // output clock model and its value at each edge
    int   oc_cnt = 0;
    logic oc_cap = 1'b0;
    always @(negedge clk) begin
        if (oc_cnt == HALF - 1) begin
            oc_cnt  <= 0;
            out_clk <= ~out_clk;
        end else begin
            oc_cnt <= oc_cnt + 1;
        end
    end
    always @(posedge clk) oc_cap <= out_clk;

    // pulse width monitor on lane 0 (R6)
    int run_p = 0, run_n = 0, runts = 0, full_runs = 0;
    always @(negedge clk) begin
        if (rst) begin
            run_p = 0; run_n = 0;
        end else begin
            if (dif_p[0]) run_p++;
            else begin
                if (run_p != 0) begin if (run_p != HALF) runts++; else full_runs++; end
                run_p = 0;
            end
            if (dif_n[0]) run_n++;
            else begin
                if (run_n != 0) begin if (run_n != HALF) runts++; else full_runs++; end
                run_n = 0;
            end
        end
    end

    // bench model
    logic [7:0] m_reg = 8'hFF;
    logic [1:0] m_mode = 2'b00;
    logic [1:0] m_addr = 2'b00;
    bit         m_started = 0;
    int         lane_pos [6] = '{0, 2, 3, 4, 6, 7};

    function automatic logic [6:0] exp_addr(input logic [1:0] s);
        return (s == 2'b00) ? 7'h6B : (s == 2'b01) ? 7'h6C : 7'h6D;
    endfunction

    function automatic logic [5:0] exp_mask();
        logic [5:0] m;
        m = '0;
        if (m_started && pwr_good && (pll_lock || m_mode == 2'b01))
            for (int i = 0; i < 6; i++) m[i] = m_reg[lane_pos[i]] & ~oe_pin_n[i];
        return m;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_lanes(input string tag, input logic [5:0] m);
        logic [11:0] a_bad, e_bad;
        bit bad;
        bad = 0; a_bad = '0; e_bad = '0;
        for (int c = 0; c < 2 * HALF; c++) begin
            @(negedge clk);
            if ({dif_p, dif_n} !== {m & {6{oc_cap}}, m & {6{~oc_cap}}} && !bad) begin
                bad = 1;
                a_bad = {dif_p, dif_n};
                e_bad = {m & {6{oc_cap}}, m & {6{~oc_cap}}};
            end
        end
        n_chk++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: actual p/n %03h expected %03h", tag, a_bad, e_bad);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = b;
        @(negedge clk);
        cfg_we = 1'b0;
        m_reg = b;
    endtask

    task automatic set_pg(input logic v);
        @(negedge clk);
        pwr_good = v;
        if (v && !m_started) begin
            m_started = 1; m_mode = strap_mode; m_addr = strap_addr;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pwr_good = 1'b0;
        m_started = 0; m_reg = 8'hFF; m_mode = 2'b00; m_addr = 2'b00;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        // R8 reset state
        do_reset();
        check("R8 reset dif_p", dif_p, 0);
        check("R8 reset dif_n", dif_n, 0);
        check("R8 reset mode_q", mode_q, 2'b00);
        check("R8 reset bus_addr", bus_addr, 7'h6B);
        @(negedge clk); rst = 1'b0;

        // R1 never started: pins and config enable everything
        settle();
        check_lanes("R1 before start", 6'h00);
        check("R1 pll_enable before start", pll_enable, 0);
        check("R1 running before start", running, 0);

        // R4 strap capture, R5 blocked until lock
        strap_mode = 2'b10; strap_addr = 2'b01;
        set_pg(1'b1);
        settle();
        check("R4 mode captured", mode_q, 2'b10);
        check("R4 addr decoded", bus_addr, 7'h6C);
        check("R5 pll_enable when running", pll_enable, 1);
        check_lanes("R5 blocked before lock", exp_mask());
        pll_lock = 1'b1;
        settle();
        check_lanes("R2 all default enabled", 6'h3F);

        // R3 spare bits and bit map
        write_cfg(8'hDD); settle();
        check_lanes("R3 spare bits cleared", exp_mask());
        write_cfg(8'h22); settle();
        check_lanes("R3 only spare bits set", 6'h00);
        for (int i = 0; i < 6; i++) begin
            write_cfg(8'(1 << lane_pos[i])); settle();
            check_lanes("R3 single lane bit", 6'(1 << i));
        end
        write_cfg(8'hFF);

        // R2 every power-good / pin / bit combination on all lanes
        for (int c = 0; c < 8; c++) begin
            set_pg(c[2]);
            oe_pin_n = {6{c[1]}};
            write_cfg({8{c[0]}});
            settle();
            check_lanes(c[2] ? "R2 combination" : "R1 power-down combination", exp_mask());
        end
        oe_pin_n = '0; write_cfg(8'hFF); set_pg(1'b1); settle();

        // R4 power-down then exit keeps straps, R1 during power-down
        set_pg(1'b0);
        strap_mode = 2'b01; strap_addr = 2'b10;
        settle();
        check("R1 pll off in power-down", pll_enable, 0);
        check("R1 running low in power-down", running, 0);
        check_lanes("R1 outputs low in power-down", 6'h00);
        set_pg(1'b1); settle();
        check("R4 mode not re-captured", mode_q, 2'b10);
        check("R4 addr not re-captured", bus_addr, 7'h6C);
        check_lanes("R4 resumed after power-down", exp_mask());

        // R2 random patterns
        for (int k = 0; k < 40; k++) begin
            oe_pin_n = 6'($urandom);
            pll_lock = ($urandom % 4) != 0;
            write_cfg(8'($urandom));
            settle();
            check_lanes("R2 random pattern", exp_mask());
        end

        // R7 pin latency: all on, then all off, each within three periods
        pll_lock = 1'b1; oe_pin_n = '0; write_cfg(8'hFF); settle();
        @(negedge clk); oe_pin_n = 6'h3F;
        settle();
        check_lanes("R7 stop within three periods", 6'h00);
        @(negedge clk); oe_pin_n = 6'h00;
        settle();
        check_lanes("R7 start within three periods", 6'h3F);

        // R5 lock loss outside bypass
        pll_lock = 1'b0; settle();
        check_lanes("R5 lock lost blocks", 6'h00);

        // R6 pulse widths seen so far
        check("R6 no shortened pulse", runts, 0);
        check("R6 full pulses observed", full_runs > 10, 1);

        // R5 bypass: lock ignored, PLL off
        do_reset();
        strap_mode = 2'b01; strap_addr = 2'b11;
        @(negedge clk); rst = 1'b0;
        oe_pin_n = 6'h05;
        set_pg(1'b1); settle();
        check("R4 bypass mode captured", mode_q, 2'b01);
        check("R4 addr 11 decoded", bus_addr, 7'h6D);
        check("R5 bypass pll off", pll_enable, 0);
        check_lanes("R5 bypass ignores lock", exp_mask());
        pll_lock = 1'b1;
        for (int k = 0; k < 8; k++) begin
            oe_pin_n = 6'($urandom);
            pll_lock = 1'($urandom);
            settle();
            check_lanes("R5 bypass random", exp_mask());
        end
        check("R6 no shortened pulse in bypass", runts, 0);

        summary();
    end

endmodule